// File: doc/BRIEF.md
# Event Frame Readout Serializer

This block drains events from an event buffer and sends each one out on a single serial line as a fixed-length frame. When the buffer reports that it holds at least one event, the block captures the event in one clock. It takes the event's pipeline address, its per-channel hit bits and the two error flags. It builds the whole frame in a parallel-load shift register and returns a one-cycle pop strobe to the buffer. It then shifts the frame out one bit per clock, most significant bit first.

A frame opens with a pair of 1 bits. Two error bits follow, and then the pipeline address. The hit bits come last, one per channel. The line rests at 0 whenever no frame is in flight, so a receiver can find each frame by its leading pair of ones. When further events are waiting, frames follow one another with no idle gap between them.

Top module: `evt_frame_ser`

## Requirements
- R1: While `rst_ni` is low, and after reset with no event stored, `ser_o`, `busy_o` and `pop_o` are all 0.
- R2: No frame starts and no pop is issued while `evt_avail_i` is 0.
- R3: The first two bits of every frame are both 1.
- R4: The third bit of a frame is the latency error flag and the fourth is the buffer-full error flag, both as they stood in the load cycle.
- R5: The next ADDR_W bits carry the event's pipeline address, most significant bit first.
- R6: The last N_CH bits carry the hit bits in channel order, channel 0 first and channel N_CH-1 last, so the frame totals 4+ADDR_W+N_CH bits.
- R7: A frame occupies exactly 4+ADDR_W+N_CH consecutive clocks on `ser_o`, and `busy_o` is high for exactly those clocks.
- R8: `pop_o` is high for a single cycle per frame: the cycle whose closing clock edge loads the frame. The first frame bit appears in the cycle that follows.
- R9: If an event is available in the last bit cycle of a frame, the next frame begins on the very next clock, with no gap and `busy_o` held high.
- R10: `ser_o` is 0 in every cycle where `busy_o` is 0.
- R11: Changes to the event inputs during a frame do not alter that frame. An event that arrives mid-frame is popped only in the last bit cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| evt_avail_i | input | 1 | Buffer holds at least one event |
| evt_addr_i | input | ADDR_W | Pipeline address of the head event |
| evt_hits_i | input | N_CH | Hit bits of the head event, bit i is channel i |
| lat_err_i | input | 1 | Latency error flag |
| full_err_i | input | 1 | Buffer-full error flag |
| ser_o | output | 1 | Serial frame data |
| busy_o | output | 1 | Frame in flight |
| pop_o | output | 1 | Pop strobe to the event buffer |

## Verification
The bench builds the block with N_CH=8 and ADDR_W=4, which gives a 16-bit frame. With this size, every frame boundary and every back-to-back handover falls within a few dozen cycles. The reduced size also makes the channel-order reversal and each field position easy to check one by one against asymmetric hit and address patterns. The bit counter still reaches its terminal value and reloads from it, as at full size. This brings within reach the arrival of an event in the middle of a frame, and three frames that run with no gap between them.

// File: rtl/evt_frame_pkg.sv
package evt_frame_pkg;
  localparam int START_BITS = 2;
  localparam int ERR_BITS   = 2;

  function automatic int frame_len(input int n_ch, input int addr_w);
    return START_BITS + ERR_BITS + addr_w + n_ch;
  endfunction
endpackage

// File: rtl/frame_pack.sv
module frame_pack #(
  parameter int N_CH    = 128,
  parameter int ADDR_W  = 8,
  parameter int FRAME_W = 140
) (
  input  logic              lat_err_i,
  input  logic              full_err_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [N_CH-1:0]   hits_i,
  output logic [FRAME_W-1:0] frame_o
);
  assign frame_o[FRAME_W-1]       = 1'b1;
  assign frame_o[FRAME_W-2]       = 1'b1;
  assign frame_o[FRAME_W-3]       = lat_err_i;
  assign frame_o[FRAME_W-4]       = full_err_i;
  assign frame_o[N_CH +: ADDR_W]  = addr_i;

  // channel 0 sits just below the address so it leaves first
  for (genvar g = 0; g < N_CH; g++) begin : g_rev
    assign frame_o[N_CH-1-g] = hits_i[g];
  end
endmodule

// File: rtl/frame_seq.sv
module frame_seq #(
  parameter int FRAME_W = 140
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic avail_i,
  output logic load_o,
  output logic busy_o
);
  localparam int CNT_W = $clog2(FRAME_W);
  localparam logic [CNT_W-1:0] CNT_TOP = CNT_W'(FRAME_W - 1);

  logic [CNT_W-1:0] cnt_q;
  logic             last_bit;

  assign last_bit = busy_o && (cnt_q == '0);
  assign load_o   = avail_i && (!busy_o || last_bit);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_o <= 1'b0;
      cnt_q  <= '0;
    end else if (load_o) begin
      busy_o <= 1'b1;
      cnt_q  <= CNT_TOP;
    end else if (busy_o) begin
      if (cnt_q == '0) busy_o <= 1'b0;
      else             cnt_q  <= cnt_q - CNT_W'(1);
    end
  end

  assert_cnt_step_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o && (cnt_q != '0) |=> busy_o && (cnt_q == $past(cnt_q) - CNT_W'(1)));

  assert_no_start_idle_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o && !avail_i |=> !busy_o);
endmodule

// File: rtl/frame_shift.sv
module frame_shift #(
  parameter int FRAME_W = 140
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               load_i,
  input  logic [FRAME_W-1:0] frame_i,
  output logic               ser_o
);
  logic [FRAME_W-1:0] sh_q;

  // zero fill: after the last bit the register is all zeros
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     sh_q <= '0;
    else if (load_i) sh_q <= frame_i;
    else             sh_q <= {sh_q[FRAME_W-2:0], 1'b0};
  end

  assign ser_o = sh_q[FRAME_W-1];
endmodule

// File: rtl/evt_frame_ser.sv
module evt_frame_ser #(
  parameter int N_CH   = 128,
  parameter int ADDR_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              evt_avail_i,
  input  logic [ADDR_W-1:0] evt_addr_i,
  input  logic [N_CH-1:0]   evt_hits_i,
  input  logic              lat_err_i,
  input  logic              full_err_i,
  output logic              ser_o,
  output logic              busy_o,
  output logic              pop_o
);
  localparam int FRAME_W = evt_frame_pkg::frame_len(N_CH, ADDR_W);

  logic [FRAME_W-1:0] frame;
  logic               load;

  frame_pack #(.N_CH(N_CH), .ADDR_W(ADDR_W), .FRAME_W(FRAME_W)) u_pack (
    .lat_err_i (lat_err_i),
    .full_err_i(full_err_i),
    .addr_i    (evt_addr_i),
    .hits_i    (evt_hits_i),
    .frame_o   (frame)
  );

  frame_seq #(.FRAME_W(FRAME_W)) u_seq (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .avail_i(evt_avail_i),
    .load_o (load),
    .busy_o (busy_o)
  );

  frame_shift #(.FRAME_W(FRAME_W)) u_shift (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .load_i (load),
    .frame_i(frame),
    .ser_o  (ser_o)
  );

  assign pop_o = load;

  assert_first_start_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pop_o |=> busy_o && ser_o);

  assert_second_start_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(pop_o, 2) |-> busy_o && ser_o);

  assert_idle_zero_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |-> !ser_o);

  assert_pop_single_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pop_o |=> !pop_o);

  assert_busy_from_pop_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy_o) |-> $past(pop_o));
endmodule

// File: tb/evt_frame_ser_bench.sv
module evt_frame_ser_bench;
  localparam int CLK_PERIOD = 10;
  localparam int N_CH   = 8;
  localparam int ADDR_W = 4;
  localparam int F      = 4 + ADDR_W + N_CH;
  localparam int CAP    = 256;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  logic [N_CH-1:0]   q_hits [0:31];
  logic [ADDR_W-1:0] q_addr [0:31];
  logic              q_lat  [0:31];
  logic              q_full [0:31];
  int head = 0;
  int tail = 0;

  logic              ser, busy, pop;
  logic              avail;
  assign avail = (head < tail);

  evt_frame_ser #(.N_CH(N_CH), .ADDR_W(ADDR_W)) u_evt_frame_ser (
    .clk_i      (clk),
    .rst_ni     (rst_n),
    .evt_avail_i(avail),
    .evt_addr_i (q_addr[head[4:0]]),
    .evt_hits_i (q_hits[head[4:0]]),
    .lat_err_i  (q_lat[head[4:0]]),
    .full_err_i (q_full[head[4:0]]),
    .ser_o      (ser),
    .busy_o     (busy),
    .pop_o      (pop)
  );

  logic pop_seen = 1'b0;
  always @(negedge clk) pop_seen <= pop;
  always @(posedge clk) begin
    #1;
    if (pop_seen) head = head + 1;
  end

  int n_tests = 0;
  int n_fail  = 0;
  logic cs [0:CAP-1];
  logic cb [0:CAP-1];
  logic cp [0:CAP-1];

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: got %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic push(input logic lat, input logic full,
                      input logic [ADDR_W-1:0] addr, input logic [N_CH-1:0] hits);
    @(posedge clk); #2;
    q_lat[tail[4:0]]  = lat;
    q_full[tail[4:0]] = full;
    q_addr[tail[4:0]] = addr;
    q_hits[tail[4:0]] = hits;
    tail = tail + 1;
  endtask

  task automatic capture(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      cs[i] = ser; cb[i] = busy; cp[i] = pop;
    end
  endtask

  function automatic int pop_at(input int from, input int n);
    for (int i = from; i < n; i++) if (cp[i]) return i;
    return -1;
  endfunction

  function automatic int pop_count(input int n);
    int c = 0;
    for (int i = 0; i < n; i++) if (cp[i]) c++;
    return c;
  endfunction

  // frame bits appear in the F cycles after the pop cycle
  task automatic check_frame(input int p, input logic lat, input logic full,
                             input logic [ADDR_W-1:0] addr, input logic [N_CH-1:0] hits);
    logic [F-1:0]    g;
    logic [N_CH-1:0] rev;
    for (int b = 0; b < F; b++) g[F-1-b] = cs[p+1+b];
    for (int c = 0; c < N_CH; c++) rev[c] = g[N_CH-1-c];
    chk(g[F-1:F-2] == 2'b11, "R3", "start bits", int'(g[F-1:F-2]), 3);
    chk(g[F-3] == lat && g[F-4] == full, "R4", "error bits",
        int'(g[F-3:F-4]), int'({lat, full}));
    chk(g[N_CH +: ADDR_W] == addr, "R5", "address", int'(g[N_CH +: ADDR_W]), int'(addr));
    chk(rev == hits, "R6", "hit bits", int'(rev), int'(hits));
  endtask

  task automatic t_reset();
    bit ok = 1;
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      if (ser || busy || pop) ok = 0;
    end
    chk(ok, "R1", "outputs in reset", int'({ser, busy, pop}), 0);
    @(posedge clk); #2; rst_n = 1'b1;
    capture(8);
    ok = 1;
    for (int i = 0; i < 8; i++) if (cs[i] || cb[i] || cp[i]) ok = 0;
    chk(ok, "R1", "idle after reset", 0, 0);
    chk(pop_count(8) == 0, "R2", "no pop while empty", pop_count(8), 0);
  endtask

  task automatic t_single();
    int p, nb;
    bit ok;
    push(1'b1, 1'b0, 4'hA, 8'b0000_0001);
    capture(F + 12);
    p = pop_at(0, F + 12);
    chk(p == 0, "R8", "pop cycle", p, 0);
    chk(pop_count(F + 12) == 1, "R8", "pop count", pop_count(F + 12), 1);
    check_frame(p, 1'b1, 1'b0, 4'hA, 8'b0000_0001);
    nb = 0; ok = 1;
    for (int i = 0; i < F + 12; i++) begin
      if (cb[i]) nb++;
      if (cb[i] != (i >= p + 1 && i <= p + F)) ok = 0;
    end
    chk(ok && nb == F, "R7", "busy window length", nb, F);
    ok = 1;
    for (int i = p + F + 1; i < F + 12; i++) if (cs[i]) ok = 0;
    chk(ok, "R10", "line low after frame", 1, 0);
  endtask

  task automatic t_err();
    push(1'b0, 1'b1, 4'h5, 8'hA5);
    capture(F + 4);
    chk(pop_at(0, F + 4) == 0, "R8", "pop cycle", pop_at(0, F + 4), 0);
    check_frame(0, 1'b0, 1'b1, 4'h5, 8'hA5);
    push(1'b1, 1'b1, 4'h3, 8'b1100_1000);
    capture(F + 4);
    check_frame(0, 1'b1, 1'b1, 4'h3, 8'b1100_1000);
  endtask

  task automatic t_b2b();
    int p0, p1, p2;
    bit ok = 1;
    @(posedge clk); #2;
    q_lat[tail[4:0]] = 1'b0; q_full[tail[4:0]] = 1'b0;
    q_addr[tail[4:0]] = 4'h1; q_hits[tail[4:0]] = 8'h0F;
    q_lat[tail[4:0]+5'd1] = 1'b1; q_full[tail[4:0]+5'd1] = 1'b0;
    q_addr[tail[4:0]+5'd1] = 4'h8; q_hits[tail[4:0]+5'd1] = 8'h3C;
    q_lat[tail[4:0]+5'd2] = 1'b0; q_full[tail[4:0]+5'd2] = 1'b1;
    q_addr[tail[4:0]+5'd2] = 4'hE; q_hits[tail[4:0]+5'd2] = 8'h81;
    tail = tail + 3;
    capture(3 * F + 8);
    p0 = pop_at(0, 3 * F + 8);
    p1 = pop_at(p0 + 1, 3 * F + 8);
    p2 = pop_at(p1 + 1, 3 * F + 8);
    chk(p1 == p0 + F, "R9", "second pop spacing", p1 - p0, F);
    chk(p2 == p0 + 2 * F, "R9", "third pop spacing", p2 - p0, 2 * F);
    for (int i = p0 + 1; i <= p0 + 3 * F; i++) if (!cb[i]) ok = 0;
    chk(ok, "R9", "busy without gap", 0, 1);
    check_frame(p0, 1'b0, 1'b0, 4'h1, 8'h0F);
    check_frame(p1, 1'b1, 1'b0, 4'h8, 8'h3C);
    check_frame(p2, 1'b0, 1'b1, 4'hE, 8'h81);
  endtask

  task automatic t_late();
    int p0, p1;
    push(1'b0, 1'b0, 4'h6, 8'h12);
    fork
      capture(2 * F + 8);
      begin
        repeat (5) @(posedge clk);
        push(1'b1, 1'b1, 4'h9, 8'hF0);
      end
    join
    p0 = pop_at(0, 2 * F + 8);
    p1 = pop_at(p0 + 1, 2 * F + 8);
    chk(p1 == p0 + F, "R11", "late event popped at last bit", p1 - p0, F);
    chk(pop_count(2 * F + 8) == 2, "R11", "pop count", pop_count(2 * F + 8), 2);
    check_frame(p0, 1'b0, 1'b0, 4'h6, 8'h12);
    check_frame(p1, 1'b1, 1'b1, 4'h9, 8'hF0);
  endtask

  initial begin
    for (int i = 0; i < 32; i++) begin
      q_hits[i] = '0; q_addr[i] = '0; q_lat[i] = 1'b0; q_full[i] = 1'b0;
    end
    t_reset();
    t_single();
    t_err();
    t_b2b();
    t_late();
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 20000);
    n_tests++; n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule